// File: doc/BRIEF.md
# Associative Tag Directory with Age-Based Replacement

This block is the tag side of a small fully associative cache. Each cache line holds the number of the memory block it currently caches, along with a valid flag and an age counter. A requester presents a block number. The directory compares it against every stored entry in the same cycle. It answers with a hit and the line index, or with a miss. On a miss it also names the line it has just filled with the presented block number.

The age counters drive replacement. A mode input selects one of two policies. In recency mode (`fifo_mode` = 0), the counters rank lines by how recently they were used. In insertion-order mode (`fifo_mode` = 1), the counters rank lines by how long ago they were filled, and hits do not change them. Only the directory is modelled here. Line data, refills from memory and write handling belong to the surrounding cache.

Top module: `assoc_tag_dir`

## Requirements
- R1: A request with `req_valid` = 1 whose block number equals the tag of a valid line gives `rsp_valid` = 1, `rsp_hit` = 1 and `rsp_line` = that line index (upper bit 0) on the clock edge that captures the request. `rsp_victim` reads 0 on a hit.
- R2: A request matching no valid line gives `rsp_hit` = 0 and `rsp_line` = all ones, a value no line index can take. The block number is written into a line in the same cycle, so an immediate repeat of that block hits.
- R3: On a miss, if any line is invalid, the lowest-index invalid line is filled and reported on `rsp_victim`.
- R4: Recency mode, hit: the hit line's age becomes 0. Every valid line whose age was strictly below the hit line's old age gains one. All other ages hold.
- R5: Recency mode, miss with every line valid: the valid line with the largest age is replaced, with the lowest index winning ties. The new line's age becomes 1 and every other line gains one.
- R6: Recency mode, miss with a free line: the filled line's age becomes 0 and every other valid line gains one.
- R7: Insertion-order mode, hit: no age changes.
- R8: Insertion-order mode, miss: the free line from R3 is filled, or else the largest-age line is replaced (lowest index on ties). The filled line's age becomes 0 and every other valid line gains one.
- R9: Ages saturate at their maximum, 2^AGE_W − 1 with AGE_W = log2(LINES), instead of wrapping. Invalid lines never age and stay at 0.
- R10: A synchronous active-high reset clears every valid flag and age and drives `rsp_valid` low. After reset every block misses and fills from line 0 upward.
- R11: `rsp_valid` mirrors `req_valid` one edge later. A cycle without a request changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe: look up and allocate on miss |
| req_block | input | BLK_W | Memory block number presented |
| fifo_mode | input | 1 | 0 = recency replacement, 1 = insertion-order replacement |
| rsp_valid | output | 1 | Response strobe, one edge after the request |
| rsp_hit | output | 1 | 1 = block found |
| rsp_line | output | log2(LINES)+1 | Matching line index, or all ones on a miss |
| rsp_victim | output | log2(LINES) | Line filled on a miss, 0 on a hit |

## Verification
Two functions meet in one cycle: the lookup of the presented block and the age update that the same lookup triggers. A full-directory miss is also where victim selection meets the fill. The directed scenarios and a long mixed sequence issue requests back to back. Each request therefore sees the ages left by the one before it, including ties and saturated values. A reference model written from the requirements predicts the hit flag, line and victim for every response. Policy switches in mid-stream and idle cycles placed between requests show that a mode change or an empty cycle disturbs neither the ordering nor the stored state.

// File: rtl/atd_pkg.sv
package atd_pkg;
  typedef enum logic {
    POL_RECENCY = 1'b0,
    POL_INSERT  = 1'b1
  } policy_e;

  function automatic int unsigned idx_width(input int unsigned lines);
    return (lines > 1) ? $clog2(lines) : 1;
  endfunction
endpackage

// File: rtl/atd_match.sv
module atd_match #(
  parameter int unsigned LINES = 128,
  parameter int unsigned BLK_W = 12,
  localparam int unsigned IDX_W = atd_pkg::idx_width(LINES)
) (
  input  logic [LINES-1:0]            valid_q,
  input  logic [LINES-1:0][BLK_W-1:0] tag_q,
  input  logic [BLK_W-1:0]            key,
  output logic [LINES-1:0]            match_vec,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  // One comparator per line, all in parallel
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match_vec[i] = valid_q[i] && (tag_q[i] == key);
  end

  assign hit = |match_vec;

  // Tags are unique, so at most one bit is set and OR-encoding is exact
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/atd_pick.sv
module atd_pick #(
  parameter int unsigned LINES = 128,
  parameter int unsigned AGE_W = 7,
  localparam int unsigned IDX_W = atd_pkg::idx_width(LINES)
) (
  input  logic [LINES-1:0]            valid_q,
  input  logic [LINES-1:0][AGE_W-1:0] age_q,
  output logic                        free_any,
  output logic [IDX_W-1:0]            free_idx,
  output logic [IDX_W-1:0]            old_idx
);
  // Lowest-index invalid line: scan downward so the lowest index wins
  always_comb begin
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end
  assign free_any = ~&valid_q;

  // Largest age, strict compare keeps the lowest index on ties.
  // Consulted only when every line is valid.
  always_comb begin
    logic [AGE_W-1:0] best;
    best    = age_q[0];
    old_idx = '0;
    for (int i = 1; i < LINES; i++) begin
      if (age_q[i] > best) begin
        best    = age_q[i];
        old_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/atd_age_update.sv
module atd_age_update #(
  parameter int unsigned LINES = 128,
  parameter int unsigned AGE_W = 7,
  localparam int unsigned IDX_W = atd_pkg::idx_width(LINES)
) (
  input  logic                        req,
  input  atd_pkg::policy_e            policy,
  input  logic                        hit,
  input  logic [IDX_W-1:0]            hit_idx,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic                        full,
  input  logic [LINES-1:0]            valid_q,
  input  logic [LINES-1:0][AGE_W-1:0] age_q,
  output logic [LINES-1:0][AGE_W-1:0] age_d
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] hit_age;
  assign hit_age = age_q[hit_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic [AGE_W-1:0] bumped;
    assign bumped = (age_q[i] == AGE_MAX) ? age_q[i] : age_q[i] + 1'b1;

    always_comb begin
      age_d[i] = age_q[i];
      if (req) begin
        if (hit) begin
          if (policy == atd_pkg::POL_RECENCY && valid_q[i]) begin
            if (MY_IDX == hit_idx)        age_d[i] = '0;
            else if (age_q[i] < hit_age)  age_d[i] = bumped;
          end
        end else begin
          if (MY_IDX == fill_idx)
            age_d[i] = (policy == atd_pkg::POL_RECENCY && full)
                       ? AGE_W'(1) : '0;
          else if (valid_q[i])
            age_d[i] = bumped;
        end
      end
    end
  end
endmodule

// File: rtl/assoc_tag_dir.sv
module assoc_tag_dir #(
  parameter int unsigned LINES = 128,
  parameter int unsigned BLK_W = 12,
  localparam int unsigned IDX_W  = atd_pkg::idx_width(LINES),
  localparam int unsigned AGE_W  = IDX_W,
  localparam int unsigned LINE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BLK_W-1:0]  req_block,
  input  logic              fifo_mode,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_line,
  output logic [IDX_W-1:0]  rsp_victim
);
  logic [LINES-1:0]            valid_q;
  logic [LINES-1:0][BLK_W-1:0] tag_q;
  logic [LINES-1:0][AGE_W-1:0] age_q, age_d;

  logic [LINES-1:0] match_vec;
  logic             hit_c, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx, old_idx, fill_idx;
  atd_pkg::policy_e policy;

  assign policy = atd_pkg::policy_e'(fifo_mode);

  atd_match #(.LINES(LINES), .BLK_W(BLK_W)) u_match (
    .valid_q  (valid_q),
    .tag_q    (tag_q),
    .key      (req_block),
    .match_vec(match_vec),
    .hit      (hit_c),
    .hit_idx  (hit_idx)
  );

  atd_pick #(.LINES(LINES), .AGE_W(AGE_W)) u_pick (
    .valid_q (valid_q),
    .age_q   (age_q),
    .free_any(free_any),
    .free_idx(free_idx),
    .old_idx (old_idx)
  );

  assign fill_idx = free_any ? free_idx : old_idx;

  atd_age_update #(.LINES(LINES), .AGE_W(AGE_W)) u_age (
    .req     (req_valid),
    .policy  (policy),
    .hit     (hit_c),
    .hit_idx (hit_idx),
    .fill_idx(fill_idx),
    .full    (~free_any),
    .valid_q (valid_q),
    .age_q   (age_q),
    .age_d   (age_d)
  );

  // Directory state
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      age_q   <= '0;
    end else begin
      age_q <= age_d;
      if (req_valid && !hit_c) begin
        valid_q[fill_idx] <= 1'b1;
        tag_q[fill_idx]   <= req_block;
      end
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_line   <= '1;
      rsp_victim <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= hit_c;
        rsp_line   <= hit_c ? {1'b0, hit_idx} : '1;
        rsp_victim <= hit_c ? '0 : fill_idx;
      end
    end
  end
endmodule

// File: rtl/atd_checks.sv
module atd_checks #(
  parameter int unsigned LINES = 128,
  parameter int unsigned BLK_W = 12,
  localparam int unsigned IDX_W  = atd_pkg::idx_width(LINES),
  localparam int unsigned AGE_W  = IDX_W,
  localparam int unsigned LINE_W = IDX_W + 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [BLK_W-1:0]            req_block,
  input logic                        fifo_mode,
  input logic                        rsp_valid,
  input logic                        rsp_hit,
  input logic [LINE_W-1:0]           rsp_line,
  input logic [LINES-1:0]            valid_q,
  input logic [LINES-1:0][AGE_W-1:0] age_q,
  input logic [LINES-1:0]            match_vec,
  input logic                        hit_c
);
  // R11: response strobe follows the request by one edge
  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_no_req_no_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R2: a miss is reported with the reserved all-ones code
  a_r2_miss_code: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_line == {LINE_W{1'b1}}));

  // R1: a hit names an existing line
  a_r1_hit_in_range: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_line < LINE_W'(LINES)));

  // R1: unique tags, so at most one comparator fires
  a_r1_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R2: a missed block is allocated and hits when repeated at once
  a_r2_repeat_hits: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit_c) ##1 (req_valid && req_block == $past(req_block))
      |=> rsp_hit);

  // R7: insertion-order hits leave every age untouched
  a_r7_fifo_hit_stable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fifo_mode && hit_c) |=> $stable(age_q));

  // R11: an idle cycle changes no state
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(age_q) && $stable(valid_q)));

  // R10: reset clears the directory
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (valid_q == '0 && !rsp_valid));

  // R9: invalid lines keep a zero age
  for (genvar i = 0; i < LINES; i++) begin : g_inv
    a_r9_invalid_age_zero: assert property (@(posedge clk) disable iff (rst)
      !valid_q[i] |-> (age_q[i] == '0));
  end
endmodule

bind assoc_tag_dir atd_checks #(.LINES(LINES), .BLK_W(BLK_W)) u_checks (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_block(req_block),
  .fifo_mode(fifo_mode),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_line (rsp_line),
  .valid_q  (valid_q),
  .age_q    (age_q),
  .match_vec(match_vec),
  .hit_c    (hit_c)
);

// File: tb/assoc_tag_dir_tb.sv
`timescale 1ns/1ps
module assoc_tag_dir_tb;
  localparam int LINES  = 8;
  localparam int BLK_W  = 12;
  localparam int IDX_W  = 3;
  localparam int LINE_W = 4;
  localparam int AMAX   = 7;
  localparam int MISS   = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [BLK_W-1:0] req_block = '0;
  logic fifo_mode = 1'b0;
  logic rsp_valid, rsp_hit;
  logic [LINE_W-1:0] rsp_line;
  logic [IDX_W-1:0] rsp_victim;

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  bit m_valid[LINES];
  int m_tag[LINES];
  int m_age[LINES];

  always #2.5 clk = ~clk;

  assoc_tag_dir #(.LINES(LINES), .BLK_W(BLK_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_block(req_block),
    .fifo_mode(fifo_mode), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_line(rsp_line), .rsp_victim(rsp_victim)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int inc(input int a);
    return (a >= AMAX) ? a : a + 1;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_age[i] = 0;
    end
    chk("R10 rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  // One request: model prediction, drive, check on the following negedge
  task automatic do_req(input int blk, input bit fifo, input string tg);
    int hidx, fidx, best, e_hit, e_line, e_vic, hage;
    bit full;
    hidx = -1;
    for (int i = 0; i < LINES; i++)
      if (m_valid[i] && m_tag[i] == blk) hidx = i;
    if (hidx >= 0) begin
      e_hit = 1; e_line = hidx; e_vic = 0;
      hage = m_age[hidx];
      if (!fifo)
        for (int i = 0; i < LINES; i++) begin
          if (!m_valid[i]) continue;
          if (i == hidx) m_age[i] = 0;
          else if (m_age[i] < hage) m_age[i] = inc(m_age[i]);
        end
    end else begin
      fidx = -1;
      for (int i = LINES - 1; i >= 0; i--) if (!m_valid[i]) fidx = i;
      full = (fidx < 0);
      if (full) begin
        fidx = 0; best = m_age[0];
        for (int i = 1; i < LINES; i++)
          if (m_age[i] > best) begin best = m_age[i]; fidx = i; end
      end
      for (int i = 0; i < LINES; i++)
        if (i != fidx && m_valid[i]) m_age[i] = inc(m_age[i]);
      m_age[fidx] = (!fifo && full) ? 1 : 0;
      m_valid[fidx] = 1; m_tag[fidx] = blk;
      e_hit = 0; e_line = MISS; e_vic = fidx;
    end
    req_valid = 1'b1; req_block = BLK_W'(blk); fifo_mode = fifo;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tg, " rsp_valid"}, int'(rsp_valid), 1);
    chk({tg, " hit"}, int'(rsp_hit), e_hit);
    chk({tg, " line"}, int'(rsp_line), e_line);
    chk({tg, " victim"}, int'(rsp_victim), e_vic);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 idle rsp_valid", int'(rsp_valid), 0);
    end
  endtask

  task automatic t_reset_fill();
    do_reset();
    for (int b = 0; b < LINES; b++) do_req(100 + b, 0, "R3 R6 fill");
    for (int b = 0; b < LINES; b++) do_req(100 + b, 0, "R1 rehit");
    do_reset();
    do_req(100, 0, "R10 miss after reset");
  endtask

  task automatic t_lru_order();
    do_reset();
    for (int b = 0; b < LINES; b++) do_req(200 + b, 0, "R6 fill");
    do_req(200, 0, "R4 hit oldest");
    do_req(203, 0, "R4 hit middle");
    do_req(300, 0, "R5 evict largest");
    do_req(301, 0, "R5 evict next");
    do_req(300, 0, "R4 hit new");
    for (int k = 0; k < 6; k++) do_req(310 + k, 0, "R5 R9 tie evict");
  endtask

  task automatic t_fifo();
    do_reset();
    for (int b = 0; b < LINES; b++) do_req(400 + b, 1, "R8 fill");
    do_req(400, 1, "R7 hit");
    do_req(401, 1, "R7 hit");
    do_req(500, 1, "R8 evict oldest");
    do_req(501, 1, "R8 evict next");
    do_req(400, 1, "R8 evicted gone");
  endtask

  task automatic t_invalid_age();
    do_reset();
    do_req(600, 0, "R9 first");
    for (int k = 0; k < 10; k++) do_req(600, 0, "R9 rehit");
    do_req(601, 1, "R9 second");
    idle(3);
    do_req(600, 1, "R11 state kept");
    for (int b = 2; b < LINES + 3; b++) do_req(600 + b, 0, "R9 fill evict");
  endtask

  task automatic t_mixed();
    int seed = 13;
    do_reset();
    for (int k = 0; k < 600; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      do_req((seed >> 8) % 14, ((k / 37) % 2) == 1, "R5 R8 mixed");
      if ((seed % 23) == 0) idle(1);
    end
  endtask

  initial begin
    #(200000 * 5ns);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_fill();
    t_lru_order();
    t_fifo();
    t_invalid_age();
    t_mixed();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule